// File: doc/BRIEF.md
# SMII Receive Segment Serializer

This block sits on the PHY side of a serial media-independent link and turns byte-wide receive information into a single serial receive line. A shared 125 MHz reference clocks both ends. The MAC pulses a framing strobe once every ten clocks, and each strobe opens a ten-bit segment that leaves the block one bit per clock. The first bit is carrier sense and the second is data-valid. The last eight bits carry either the received byte or, between frames, a snapshot of link status.

At 100 Mbps every segment carries a freshly captured sample. At 10 Mbps a sample is captured only on every tenth segment and is otherwise resent unchanged, so one byte spans ten segments. A one-cycle pulse on `sample_o` tells the upstream byte source that its current byte or status has been taken. Between frames the status snapshot includes an error flag that remembers whether the frame that just ended carried a receive error.

Top module: `smii_rx_serializer`

## Requirements
- R1: While reset is asserted and after release until the first strobe, `rxd_o` and `sample_o` are 0.
- R2: The segment opened by a strobe sampled at clock edge E appears on `rxd_o` in the ten cycles after edges E through E+9, in the order carrier sense, data-valid, then payload bit 0 up to payload bit 7.
- R3: When data-valid is 1 at capture, payload bits 0..7 equal `rx_data_i[0]`..`rx_data_i[7]`.
- R4: When data-valid is 0 at capture, the payload bits are as follows. Bit 0 is the previous-frame error, bit 1 is speed (1 = 100 Mbps), bit 2 is duplex (1 = full), bit 3 is link (1 = up), bit 4 is jabber (1 = detected), bit 5 is upper-nibble valid (1 = valid), bit 6 is false carrier (1 = detected), and bit 7 is always 1.
- R5: The previous-frame error becomes 1 when data-valid falls after a frame in which `rx_er_i` was high while data-valid was high. It becomes 0 when data-valid next rises. A frame end seen on the same edge as a capture is already reflected in that capture.
- R6: At 100 Mbps every strobe captures a new sample, and `sample_o` is 1 in the cycle after each strobe edge.
- R7: At 10 Mbps a sample is captured on the first strobe after entering that mode and on every tenth strobe after it. The other nine segments repeat it exactly, and `sample_o` stays 0 after those strobes.
- R8: A strobe arriving before ten bits have been sent abandons the current segment, and the new segment starts at once.
- R9: Once ten bits have been sent and no new strobe has arrived, `rxd_o` is 0.
- R10: Input changes during a segment do not alter the bits of that segment.
- R11: `sample_o` is 1 only in the cycle after a strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Segment strobe from the MAC |
| rx_crs_i | input | 1 | Carrier sense |
| rx_dv_i | input | 1 | Receive data valid |
| rx_er_i | input | 1 | Receive error |
| rx_data_i | input | 8 | Received byte |
| speed_100_i | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| full_duplex_i | input | 1 | Duplex status |
| link_up_i | input | 1 | Link status |
| jabber_i | input | 1 | Jabber detected |
| upper_valid_i | input | 1 | Upper nibble valid |
| false_carrier_i | input | 1 | False carrier detected |
| rxd_o | output | 1 | Serial receive data |
| sample_o | output | 1 | Pulse: a new sample was captured |

## Verification
Two events can fall on the same clock edge: the end of a frame, which updates the remembered error, and the segment capture that builds the next status byte. The bench provokes this by lowering data-valid at the falling clock edge just before a strobe edge that follows an errored frame. It then expects payload bit 0 of that very status segment to read 1. A second coincidence occurs when an early strobe lands mid-segment together with a fresh capture. There the bench expects the new word to be complete and correct, with no bits left over from the abandoned segment.

// File: rtl/smii_rx_pkg.sv
package smii_rx_pkg;

   typedef struct packed {
      logic false_carrier;
      logic upper_valid;
      logic jabber;
      logic link_up;
      logic full_duplex;
      logic speed_100;
   } smii_link_t;

   // Status byte, bit 0 first on the wire after the two flag bits.
   function automatic logic [7:0] status_byte(input smii_link_t lk, input logic prev_err);
      logic [7:0] s;
      s[0] = prev_err;
      s[1] = lk.speed_100;
      s[2] = lk.full_duplex;
      s[3] = lk.link_up;
      s[4] = lk.jabber;
      s[5] = lk.upper_valid;
      s[6] = lk.false_carrier;
      s[7] = 1'b1;
      return s;
   endfunction

endpackage

// File: rtl/smii_seg_timer.sv
module smii_seg_timer #(
   parameter int SEG_LEN    = 10,
   parameter int REPEAT_10M = 10,
   localparam int CW = $clog2(SEG_LEN + 1),
   localparam int RW = (REPEAT_10M > 1) ? $clog2(REPEAT_10M) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync,
   input  logic          speed_100,
   output logic [CW-1:0] bit_idx,
   output logic          take_new,
   output logic          sample_q
);

   logic [RW-1:0] rep_cnt;

   assign take_new = sync && (speed_100 || (rep_cnt == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_idx <= CW'(SEG_LEN);
      end else if (sync) begin
         bit_idx <= CW'(1);
      end else if (bit_idx < CW'(SEG_LEN)) begin
         bit_idx <= bit_idx + CW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rep_cnt <= '0;
      end else if (speed_100) begin
         rep_cnt <= '0;
      end else if (sync) begin
         if (rep_cnt == RW'(REPEAT_10M - 1)) rep_cnt <= '0;
         else                                rep_cnt <= rep_cnt + RW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sample_q <= 1'b0;
      else        sample_q <= take_new;
   end

endmodule

// File: rtl/smii_err_track.sv
module smii_err_track (
   input  logic clk,
   input  logic rst_n,
   input  logic dv,
   input  logic er,
   output logic prev_err_nxt,
   output logic prev_err_q
);

   logic dv_q;
   logic err_acc;
   logic frame_end;
   logic frame_start;

   assign frame_end   = dv_q && !dv;
   assign frame_start = !dv_q && dv;

   always_comb begin
      prev_err_nxt = prev_err_q;
      if (frame_end)        prev_err_nxt = err_acc;
      else if (frame_start) prev_err_nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dv_q       <= 1'b0;
         err_acc    <= 1'b0;
         prev_err_q <= 1'b0;
      end else begin
         dv_q       <= dv;
         prev_err_q <= prev_err_nxt;
         if (frame_end)      err_acc <= 1'b0;
         else if (dv && er)  err_acc <= 1'b1;
      end
   end

endmodule

// File: rtl/smii_seg_builder.sv
module smii_seg_builder
   import smii_rx_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int SEG_LEN = DATA_W + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take_new,
   input  logic               crs,
   input  logic               dv,
   input  logic [DATA_W-1:0]  data,
   input  smii_link_t         link,
   input  logic               prev_err,
   output logic [SEG_LEN-1:0] seg_word,
   output logic [SEG_LEN-1:0] seg_q
);

   logic [SEG_LEN-1:0] fresh;
   logic [DATA_W-1:0]  payload;

   always_comb begin
      payload = dv ? data : DATA_W'(status_byte(link, prev_err));
      fresh   = {payload, dv, crs};
   end

   assign seg_word = take_new ? fresh : seg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        seg_q <= '0;
      else if (take_new) seg_q <= fresh;
   end

endmodule

// File: rtl/smii_bit_out.sv
module smii_bit_out #(
   parameter int SEG_LEN   = 10,
   parameter bit USE_SHIFT = 1'b1,
   localparam int CW = $clog2(SEG_LEN + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sync,
   input  logic [SEG_LEN-1:0] seg_word,
   input  logic [CW-1:0]      bit_idx,
   output logic               rxd
);

   generate
      if (USE_SHIFT) begin : g_shift
         logic [SEG_LEN-2:0] rest;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rxd  <= 1'b0;
               rest <= '0;
            end else if (sync) begin
               rxd  <= seg_word[0];
               rest <= seg_word[SEG_LEN-1:1];
            end else if (bit_idx < CW'(SEG_LEN)) begin
               rxd  <= rest[0];
               rest <= {1'b0, rest[SEG_LEN-2:1]};
            end else begin
               rxd  <= 1'b0;
            end
         end
      end else begin : g_mux
         logic [SEG_LEN-1:0] hold;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rxd  <= 1'b0;
               hold <= '0;
            end else if (sync) begin
               rxd  <= seg_word[0];
               hold <= seg_word;
            end else if (bit_idx < CW'(SEG_LEN)) begin
               rxd  <= hold[bit_idx];
            end else begin
               rxd  <= 1'b0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/smii_rx_serializer.sv
module smii_rx_serializer
   import smii_rx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int REPEAT_10M = 10,
   parameter bit USE_SHIFT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_i,
   input  logic              rx_crs_i,
   input  logic              rx_dv_i,
   input  logic              rx_er_i,
   input  logic [DATA_W-1:0] rx_data_i,
   input  logic              speed_100_i,
   input  logic              full_duplex_i,
   input  logic              link_up_i,
   input  logic              jabber_i,
   input  logic              upper_valid_i,
   input  logic              false_carrier_i,
   output logic              rxd_o,
   output logic              sample_o
);

   localparam int SEG_LEN = DATA_W + 2;
   localparam int CW      = $clog2(SEG_LEN + 1);

   if (DATA_W != 8) begin : g_bad_width
      $error("smii_rx_serializer: DATA_W must be 8");
   end
   if (REPEAT_10M < 2) begin : g_bad_repeat
      $error("smii_rx_serializer: REPEAT_10M must be at least 2");
   end

   smii_link_t         link;
   logic [CW-1:0]      bit_idx;
   logic               take_new;
   logic               prev_err_nxt;
   logic               prev_err_q;
   logic [SEG_LEN-1:0] seg_word;
   logic [SEG_LEN-1:0] seg_q;

   always_comb begin
      link.false_carrier = false_carrier_i;
      link.upper_valid   = upper_valid_i;
      link.jabber        = jabber_i;
      link.link_up       = link_up_i;
      link.full_duplex   = full_duplex_i;
      link.speed_100     = speed_100_i;
   end

   smii_seg_timer #(.SEG_LEN(SEG_LEN), .REPEAT_10M(REPEAT_10M)) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync      (sync_i),
      .speed_100 (speed_100_i),
      .bit_idx   (bit_idx),
      .take_new  (take_new),
      .sample_q  (sample_o)
   );

   smii_err_track i_err (
      .clk          (clk),
      .rst_n        (rst_n),
      .dv           (rx_dv_i),
      .er           (rx_er_i),
      .prev_err_nxt (prev_err_nxt),
      .prev_err_q   (prev_err_q)
   );

   smii_seg_builder #(.DATA_W(DATA_W)) i_build (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_new (take_new),
      .crs      (rx_crs_i),
      .dv       (rx_dv_i),
      .data     (rx_data_i),
      .link     (link),
      .prev_err (prev_err_nxt),
      .seg_word (seg_word),
      .seg_q    (seg_q)
   );

   smii_bit_out #(.SEG_LEN(SEG_LEN), .USE_SHIFT(USE_SHIFT)) i_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync     (sync_i),
      .seg_word (seg_word),
      .bit_idx  (bit_idx),
      .rxd      (rxd_o)
   );

endmodule

// File: rtl/smii_rx_checker.sv
module smii_rx_checker #(
   parameter int SEG_LEN = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sync_i,
   input logic               speed_100_i,
   input logic               rx_crs_i,
   input logic               rx_dv_i,
   input logic               rxd_o,
   input logic               sample_o,
   input logic               take_new,
   input logic [SEG_LEN-1:0] seg_q,
   input logic               prev_err_q
);

   localparam int CW = $clog2(SEG_LEN + 1);
   logic [CW-1:0] since_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             since_sync <= CW'(SEG_LEN);
      else if (sync_i)                        since_sync <= CW'(1);
      else if (since_sync < CW'(SEG_LEN))     since_sync <= since_sync + CW'(1);
   end

   // R6
   a_r6_sample_every_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_i && speed_100_i) |=> sample_o);

   // R11
   a_r11_sample_only_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_i |=> !sample_o);

   // R9
   a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      (since_sync == CW'(SEG_LEN) && !sync_i) |=> !rxd_o);

   // R2
   a_r2_crs_first: assert property (@(posedge clk) disable iff (!rst_n)
      take_new |=> (rxd_o == $past(rx_crs_i)));

   // R10
   a_r10_segment_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_i |=> $stable(seg_q));

   // R5
   a_r5_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_dv_i) |=> !prev_err_q);

endmodule

bind smii_rx_serializer smii_rx_checker #(.SEG_LEN(SEG_LEN)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sync_i      (sync_i),
   .speed_100_i (speed_100_i),
   .rx_crs_i    (rx_crs_i),
   .rx_dv_i     (rx_dv_i),
   .rxd_o       (rxd_o),
   .sample_o    (sample_o),
   .take_new    (take_new),
   .seg_q       (seg_q),
   .prev_err_q  (prev_err_q)
);

// File: tb/test_smii_rx_serializer.sv
module test_smii_rx_serializer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_i = 1'b0;
   logic       rx_crs_i = 1'b0;
   logic       rx_dv_i = 1'b0;
   logic       rx_er_i = 1'b0;
   logic [7:0] rx_data_i = 8'h00;
   logic       speed_100_i = 1'b1;
   logic       full_duplex_i = 1'b0;
   logic       link_up_i = 1'b0;
   logic       jabber_i = 1'b0;
   logic       upper_valid_i = 1'b0;
   logic       false_carrier_i = 1'b0;
   logic       rxd_o;
   logic       sample_o;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   smii_rx_serializer i_smii_rx_serializer (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .rx_crs_i(rx_crs_i),
      .rx_dv_i(rx_dv_i), .rx_er_i(rx_er_i), .rx_data_i(rx_data_i),
      .speed_100_i(speed_100_i), .full_duplex_i(full_duplex_i),
      .link_up_i(link_up_i), .jabber_i(jabber_i), .upper_valid_i(upper_valid_i),
      .false_carrier_i(false_carrier_i), .rxd_o(rxd_o), .sample_o(sample_o)
   );

   // Row: [15] dv, [14] crs, [13] er, [12:5] data, [4:0] {fc, uv, jab, link, dup}
   localparam logic [15:0] VEC [8] = '{
      {1'b0, 1'b0, 1'b0, 8'h00, 5'b00011},
      {1'b0, 1'b1, 1'b0, 8'h00, 5'b10100},
      {1'b1, 1'b1, 1'b0, 8'hA5, 5'b00011},
      {1'b1, 1'b1, 1'b1, 8'h3C, 5'b00011},
      {1'b0, 1'b0, 1'b0, 8'h00, 5'b01011},
      {1'b1, 1'b1, 1'b0, 8'hFF, 5'b00011},
      {1'b1, 1'b0, 1'b0, 8'h00, 5'b00011},
      {1'b0, 1'b0, 1'b0, 8'h00, 5'b11111}
   };

   function automatic logic [9:0] exp_word(input logic crs, input logic dv, input logic [7:0] d,
                                           input logic [4:0] lk, input logic spd, input logic prev);
      logic [7:0] pay;
      pay = dv ? d : {1'b1, lk[4], lk[3], lk[2], lk[1], lk[0], spd, prev};
      return {pay, dv, crs};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [9:0] act, input logic [9:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [15:0] v);
      rx_dv_i         = v[15];
      rx_crs_i        = v[14];
      rx_er_i         = v[13];
      rx_data_i       = v[12:5];
      false_carrier_i = v[4];
      upper_valid_i   = v[3];
      jabber_i        = v[2];
      link_up_i       = v[1];
      full_duplex_i   = v[0];
   endtask

   // Called at a falling edge; raises the strobe and gathers n bits.
   task automatic run_seg(input int n, input bit scramble, output logic [9:0] bits, output logic smp);
      bits = '0;
      smp  = 1'b0;
      sync_i = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (i == 0) begin
            sync_i = 1'b0;
            smp = sample_o;
         end
         bits[i] = rxd_o;
         if (scramble && i == 3) begin
            rx_data_i = ~rx_data_i;
            rx_crs_i  = ~rx_crs_i;
            rx_dv_i   = ~rx_dv_i;
         end
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 10'h0, 10'h0);
      finish_run();
   end

   initial begin
      logic [9:0] bits;
      logic [9:0] exp;
      logic [9:0] first;
      logic       smp;
      logic       m_prev;
      logic       m_acc;
      logic       m_dv;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(rxd_o == 1'b0 && sample_o == 1'b0, "R1 reset", {8'h0, sample_o, rxd_o}, 10'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(rxd_o == 1'b0 && sample_o == 1'b0, "R1 before first strobe", {8'h0, sample_o, rxd_o}, 10'h0);

      // R2 R3 R4 R5 R6: table walk at 100 Mbps
      m_prev = 1'b0; m_acc = 1'b0; m_dv = 1'b0;
      for (int k = 0; k < 8; k++) begin
         apply(VEC[k]);
         if (m_dv && !VEC[k][15]) begin m_prev = m_acc; m_acc = 1'b0; end
         if (!m_dv && VEC[k][15]) m_prev = 1'b0;
         if (VEC[k][15] && VEC[k][13]) m_acc = 1'b1;
         m_dv = VEC[k][15];
         exp = exp_word(VEC[k][14], VEC[k][15], VEC[k][12:5], VEC[k][4:0], 1'b1, m_prev);
         run_seg(10, 1'b0, bits, smp);
         chk(bits == exp, $sformatf("R2 R3 R4 R5 row %0d", k), bits, exp);
         chk(smp == 1'b1, "R6 sample pulse", {9'h0, smp}, 10'h1);
      end

      // R10: inputs flipped mid-segment do not disturb it
      apply({1'b1, 1'b1, 1'b0, 8'h5A, 5'b00011});
      exp = exp_word(1'b1, 1'b1, 8'h5A, 5'b00011, 1'b1, 1'b0);
      run_seg(10, 1'b1, bits, smp);
      chk(bits == exp, "R10 mid-segment change", bits, exp);

      // R9: no strobe after ten bits
      for (int j = 0; j < 3; j++) begin
         @(posedge clk);
         @(negedge clk);
         chk(rxd_o == 1'b0, "R9 idle low", {9'h0, rxd_o}, 10'h0);
      end

      // R8: early strobe after four bits
      apply({1'b1, 1'b1, 1'b0, 8'h81, 5'b00011});
      exp = exp_word(1'b1, 1'b1, 8'h81, 5'b00011, 1'b1, 1'b0);
      run_seg(4, 1'b0, bits, smp);
      chk(bits[3:0] == exp[3:0], "R8 partial head", {6'h0, bits[3:0]}, {6'h0, exp[3:0]});
      apply({1'b1, 1'b0, 1'b0, 8'h7E, 5'b00011});
      exp = exp_word(1'b0, 1'b1, 8'h7E, 5'b00011, 1'b1, 1'b0);
      run_seg(10, 1'b0, bits, smp);
      chk(bits == exp && smp, "R8 realigned segment", bits, exp);

      // R5: frame end on the same edge as the status capture
      apply({1'b1, 1'b1, 1'b1, 8'h11, 5'b00011});
      run_seg(10, 1'b0, bits, smp);
      apply({1'b0, 1'b1, 1'b0, 8'h00, 5'b00111});
      exp = exp_word(1'b1, 1'b0, 8'h00, 5'b00111, 1'b1, 1'b1);
      run_seg(10, 1'b0, bits, smp);
      chk(bits == exp, "R5 coincident frame end", bits, exp);

      // R7: 10 Mbps repetition
      speed_100_i = 1'b0;
      apply({1'b0, 1'b0, 1'b0, 8'h00, 5'b01010});
      first = exp_word(1'b0, 1'b0, 8'h00, 5'b01010, 1'b0, 1'b1);
      run_seg(10, 1'b0, bits, smp);
      chk(bits == first && smp, "R7 first capture at 10 Mbps", bits, first);
      apply({1'b1, 1'b1, 1'b0, 8'hC3, 5'b10101});
      for (int r = 1; r < 10; r++) begin
         run_seg(10, 1'b0, bits, smp);
         chk(bits == first, "R7 repeated segment", bits, first);
         chk(smp == 1'b0, "R7 no sample on repeat", {9'h0, smp}, 10'h0);
      end
      exp = exp_word(1'b1, 1'b1, 8'hC3, 5'b10101, 1'b0, 1'b0);
      run_seg(10, 1'b0, bits, smp);
      chk(bits == exp && smp, "R7 tenth-strobe capture", bits, exp);

      finish_run();
   end

endmodule